// File: doc/BRIEF.md
# Synchronized PWM Shadow Update Controller

This block holds four independent pulse-width generators. Each one has a down-counter, an active period value and an active threshold value. Software never writes the active values directly. It writes new period and threshold values into shadow copies through a single-cycle register write port. It then requests a commit for that generator by setting the generator's bit in a control register.

A commit request waits for the generator's own counter to reach zero. In that cycle the shadow copies are moved into the active registers and the request bit drops by itself. Software cannot withdraw a request. Writing a zero to the bit does nothing, and writing a one again while the bit is set does not add a second request. The control register can be read back at all times and shows which requests are still waiting.

Each generator has a two-state request machine. In `SYNC_IDLE`, a write of 1 to its control bit takes the **ARM** transition to `SYNC_ARMED`. In `SYNC_ARMED`, reaching counter zero takes the **COMMIT** transition back to `SYNC_IDLE`. In every other case each state holds.

Top module: `pwm_sync_ctrl`

## Requirements
- R1: After reset, every request bit is 0, the control readback is 0, and each generator starts with period 9 and threshold 4. With these values all four outputs are high.
- R2: The control readback carries the request bit of generator n at bit position n for n = 0..3. Bits 31..4 always read zero.
- R3: A write to address 0 with data bit n equal to 1 sets request bit n. The readback shows it on the cycle after the write.
- R4: Writing 0 to a request bit leaves a pending request in place. Writing 1 to a bit that is already set does not create a second request, so exactly one commit follows.
- R5: Each counter counts down by one per cycle from its active period value to zero and then reloads, so one PWM period lasts (period + 1) cycles.
- R6: A generator's output is high while its count is strictly greater than its active threshold, and low otherwise.
- R7: A write to address 1+2n changes the shadow period of generator n, and a write to address 2+2n changes its shadow threshold. With no request set, the output waveform keeps its old period and duty.
- R8: In the cycle where a generator's count is zero and its request is set, the shadow values become active, the counter reloads with the new period, and the request bit clears.
- R9: When a shadow register is written several times before a commit, the last value written is the one committed.
- R10: Each generator commits only on its own counter-zero event. Activity in one generator leaves the others' periods and duty unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address: 0 control, 1+2n shadow period, 2+2n shadow threshold |
| wr_data | input | 32 | Write data |
| ctrl_rd_data | output | 32 | Control register readback of the pending request bits |
| pwm_o | output | 4 | One PWM output per generator |

## Verification
A write presented before a rising edge takes effect at that edge. A newly armed request therefore shows in the readback one cycle after its write. A commit updates the count, the threshold and the request bit at the edge where the count is zero, so the output reflects the new values in the cycle after the zero. A reference model steps at every rising edge using the same inputs and queues the expected outputs and readback. The monitor pops those values at the following falling edge, which is where the registered results have settled. Period and duty measurements start at a rising output edge and count whole cycles until the next one.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    // Per-generator commit request machine
    typedef enum logic {
        SYNC_IDLE  = 1'b0,   // no commit waiting
        SYNC_ARMED = 1'b1    // commit waits for counter zero
    } sync_state_e;

    // Register map: control at 0, then period/threshold pairs per generator
    localparam int unsigned CTRL_ADDR = 0;

    function automatic int unsigned period_addr(input int unsigned gen);
        return 1 + 2 * gen;
    endfunction

    function automatic int unsigned thresh_addr(input int unsigned gen);
        return 2 + 2 * gen;
    endfunction

endpackage

// File: rtl/pwm_reg_decode.sv
module pwm_reg_decode
    import pwm_sync_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_GEN-1:0] sync_req,
    output logic [NUM_GEN-1:0] period_we,
    output logic [NUM_GEN-1:0] thresh_we,
    output logic [CNT_W-1:0]   wval
);

    logic ctrl_hit;
    logic unused_hi;

    always_comb begin
        ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
        wval     = wr_data[CNT_W-1:0];
    end

    assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_dec
        always_comb begin
            sync_req[g]  = ctrl_hit && wr_data[g];
            period_we[g] = wr_en && (wr_addr == ADDR_W'(period_addr(g)));
            thresh_we[g] = wr_en && (wr_addr == ADDR_W'(thresh_addr(g)));
        end
    end

endmodule

// File: rtl/pwm_gen_unit.sv
module pwm_gen_unit
    import pwm_sync_pkg::*;
#(
    parameter int              CNT_W    = 16,
    parameter logic [CNT_W-1:0] RST_LOAD = 16'd9,
    parameter logic [CNT_W-1:0] RST_CMP  = 16'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_we,
    input  logic             thresh_we,
    input  logic [CNT_W-1:0] wval,
    input  logic             sync_req,
    output logic             pwm_o,
    output logic             sync_o,
    output logic             zero_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_load_o
);

    sync_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_load_q, act_cmp_q;
    logic [CNT_W-1:0] sh_load_q, sh_cmp_q;
    logic             at_zero;
    logic             commit;

    always_comb begin
        at_zero = (cnt_q == '0);
        commit  = (state_q == SYNC_ARMED) && at_zero;
    end

    // Next-state logic: ARM from idle, COMMIT from armed at counter zero
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_IDLE:  if (sync_req) state_d = SYNC_ARMED;
            SYNC_ARMED: if (at_zero)  state_d = SYNC_IDLE;
            default:    state_d = SYNC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SYNC_IDLE;
        else        state_q <= state_d;
    end

    // Shadow copies: last write wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_load_q <= RST_LOAD;
            sh_cmp_q  <= RST_CMP;
        end else begin
            if (period_we) sh_load_q <= wval;
            if (thresh_we) sh_cmp_q  <= wval;
        end
    end

    // Active pair: only the commit moves shadow to active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_load_q <= RST_LOAD;
            act_cmp_q  <= RST_CMP;
        end else if (commit) begin
            act_load_q <= sh_load_q;
            act_cmp_q  <= sh_cmp_q;
        end
    end

    // Down-counter with reload from the value active after this edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= RST_LOAD;
        else if (at_zero) cnt_q <= commit ? sh_load_q : act_load_q;
        else              cnt_q <= cnt_q - 1'b1;
    end

    // Output process
    always_comb begin
        pwm_o      = (cnt_q > act_cmp_q);
        sync_o     = (state_q == SYNC_ARMED);
        zero_o     = at_zero;
        cnt_o      = cnt_q;
        act_load_o = act_load_q;
    end

endmodule

// File: rtl/pwm_sync_ctrl.sv
module pwm_sync_ctrl
    import pwm_sync_pkg::*;
#(
    parameter int              NUM_GEN  = 4,
    parameter int              ADDR_W   = 4,
    parameter int              CNT_W    = 16,
    parameter logic [CNT_W-1:0] RST_LOAD = 16'd9,
    parameter logic [CNT_W-1:0] RST_CMP  = 16'd4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        ctrl_rd_data,
    output logic [NUM_GEN-1:0] pwm_o
);

    localparam int DATA_W = 32;
    localparam int FLAT_W = NUM_GEN * CNT_W;

    logic [NUM_GEN-1:0] sync_req, period_we, thresh_we;
    logic [NUM_GEN-1:0] sync_vec, zero_vec;
    logic [CNT_W-1:0]   wval;
    logic [FLAT_W-1:0]  cnt_flat, act_load_flat;

    pwm_reg_decode #(
        .NUM_GEN (NUM_GEN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W)
    ) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sync_req  (sync_req),
        .period_we (period_we),
        .thresh_we (thresh_we),
        .wval      (wval)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_unit
        pwm_gen_unit #(
            .CNT_W    (CNT_W),
            .RST_LOAD (RST_LOAD),
            .RST_CMP  (RST_CMP)
        ) u_gen (
            .clk        (clk),
            .rst_n      (rst_n),
            .period_we  (period_we[g]),
            .thresh_we  (thresh_we[g]),
            .wval       (wval),
            .sync_req   (sync_req[g]),
            .pwm_o      (pwm_o[g]),
            .sync_o     (sync_vec[g]),
            .zero_o     (zero_vec[g]),
            .cnt_o      (cnt_flat[g*CNT_W +: CNT_W]),
            .act_load_o (act_load_flat[g*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        ctrl_rd_data                = '0;
        ctrl_rd_data[NUM_GEN-1:0]   = sync_vec;
    end

endmodule

// File: rtl/pwm_sync_ctrl_checker.sv
module pwm_sync_ctrl_checker #(
    parameter int NUM_GEN = 4,
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [31:0]              wr_data,
    input logic [31:0]              ctrl_rd_data,
    input logic [NUM_GEN-1:0]       sync_vec,
    input logic [NUM_GEN-1:0]       zero_vec,
    input logic [NUM_GEN*CNT_W-1:0] cnt_flat,
    input logic [NUM_GEN*CNT_W-1:0] act_load_flat
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == '0);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd_data[31:NUM_GEN] == '0);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        assert_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && wr_data[g] && !(sync_vec[g] && zero_vec[g])) |=> sync_vec[g]);

        assert_hold_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_vec[g] && !zero_vec[g]) |=> sync_vec[g]);

        assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !zero_vec[g] |=> cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) - 1'b1);

        assert_active_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(sync_vec[g] && zero_vec[g]) |=> $stable(act_load_flat[g*CNT_W +: CNT_W]));

        assert_commit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_vec[g] && zero_vec[g]) |=>
                (!sync_vec[g] && cnt_flat[g*CNT_W +: CNT_W] == act_load_flat[g*CNT_W +: CNT_W]));
    end

endmodule

bind pwm_sync_ctrl pwm_sync_ctrl_checker #(
    .NUM_GEN (NUM_GEN),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ctrl_rd_data  (ctrl_rd_data),
    .sync_vec      (sync_vec),
    .zero_vec      (zero_vec),
    .cnt_flat      (cnt_flat),
    .act_load_flat (act_load_flat)
);

// File: tb/pwm_sync_ctrl_bench.sv
module pwm_sync_ctrl_bench;

    localparam int NG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rd_data;
    logic [3:0]  pwm_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pwm_sync_ctrl u_pwm_sync_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ctrl_rd_data (ctrl_rd_data),
        .pwm_o        (pwm_o)
    );

    // ---------------- reference model and scoreboard ----------------
    typedef struct packed {
        logic [3:0]  pwm;
        logic [31:0] ctrl;
    } exp_t;

    exp_t exp_q[$];

    int m_cnt[NG], m_ld[NG], m_cm[NG], m_sl[NG], m_sc[NG];
    bit m_sync[NG];

    initial begin
        forever begin
            @(posedge clk);
            begin
                exp_t e;
                for (int g = 0; g < NG; g++) begin
                    if (!rst_n) begin
                        m_cnt[g] = 9; m_ld[g] = 9; m_cm[g] = 4;
                        m_sl[g] = 9;  m_sc[g] = 4; m_sync[g] = 0;
                    end else begin
                        bit zero, com;
                        zero = (m_cnt[g] == 0);
                        com  = zero && m_sync[g];
                        if (com) begin
                            m_ld[g] = m_sl[g];
                            m_cm[g] = m_sc[g];
                        end
                        m_cnt[g] = zero ? m_ld[g] : m_cnt[g] - 1;
                        if (com) m_sync[g] = 0;
                        else if (wr_en && wr_addr == 0 && wr_data[g]) m_sync[g] = 1;
                        if (wr_en && wr_addr == 4'(1 + 2*g)) m_sl[g] = int'(wr_data[15:0]);
                        if (wr_en && wr_addr == 4'(2 + 2*g)) m_sc[g] = int'(wr_data[15:0]);
                    end
                end
                e.ctrl = '0;
                for (int g = 0; g < NG; g++) begin
                    e.pwm[g]  = (m_cnt[g] > m_cm[g]);
                    e.ctrl[g] = m_sync[g];
                end
                exp_q.push_back(e);
            end
        end
    end

    // Monitor: R5/R6/R8 via waveform, R2/R3/R4 via readback
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (pwm_o !== e.pwm) begin
                    miscompares++;
                    $display("FAIL R6 pwm got %h exp %h at %0t", pwm_o, e.pwm, $time);
                end
                vectors++;
                if (ctrl_rd_data !== e.ctrl) begin
                    miscompares++;
                    $display("FAIL R2 ctrl got %h exp %h at %0t", ctrl_rd_data, e.ctrl, $time);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic wait_rise(input int g);
        logic prev;
        prev = pwm_o[g];
        forever begin
            @(negedge clk);
            if (pwm_o[g] && !prev) break;
            prev = pwm_o[g];
        end
    endtask

    task automatic measure(input int g, output int per, output int hi);
        logic prev;
        wait_rise(g);
        per = 0; hi = 0;
        forever begin
            hi += int'(pwm_o[g]);
            per++;
            prev = pwm_o[g];
            @(negedge clk);
            if (pwm_o[g] && !prev) break;
        end
    endtask

    task automatic wait_clear(input int g);
        while (ctrl_rd_data[g]) @(negedge clk);
    endtask

    // ---------------- directed stimulus ----------------
    initial begin
        int per, hi;
        repeat (5) @(negedge clk);
        check("R1 ctrl after reset", int'(ctrl_rd_data), 0);
        check("R1 pwm after reset", int'(pwm_o), 15);
        rst_n = 1'b1;

        measure(0, per, hi);
        check("R5 reset period", per, 10);
        check("R6 reset high cycles", hi, 5);

        // R7: shadow writes alone change nothing
        write_reg(4'd1, 32'd3);
        write_reg(4'd2, 32'd1);
        measure(0, per, hi);
        check("R7 period unchanged", per, 10);
        check("R7 duty unchanged", hi, 5);
        check("R7 no request", int'(ctrl_rd_data), 0);

        // R3 / R4 on generator 0
        wait_rise(0);
        write_reg(4'd0, 32'h1);
        check("R3 bit0 set", int'(ctrl_rd_data[0]), 1);
        write_reg(4'd0, 32'h0);
        check("R4 zero write ignored", int'(ctrl_rd_data[0]), 1);
        wait_clear(0);
        check("R8 self clear", int'(ctrl_rd_data[0]), 0);
        measure(0, per, hi);
        check("R8 new period", per, 4);
        check("R8 new duty", hi, 2);

        // R9 and double request on generator 1
        write_reg(4'd3, 32'd5);
        write_reg(4'd3, 32'd7);
        write_reg(4'd4, 32'd2);
        wait_rise(1);
        write_reg(4'd0, 32'h2);
        write_reg(4'd0, 32'h2);
        wait_clear(1);
        measure(1, per, hi);
        check("R9 last period wins", per, 8);
        check("R9 last threshold", hi, 5);
        check("R4 single commit", int'(ctrl_rd_data[1]), 0);

        // R10: generator 2 untouched
        measure(2, per, hi);
        check("R10 gen2 period", per, 10);
        check("R10 gen2 duty", hi, 5);
        measure(0, per, hi);
        check("R10 gen0 period", per, 4);

        // R2: all bits written
        write_reg(4'd0, 32'hFFFF_FFFF);
        check("R2 readback", int'(ctrl_rd_data), 15);
        while (ctrl_rd_data != 0) @(negedge clk);
        check("R2 all cleared", int'(ctrl_rd_data), 0);

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule